// File: doc/BRIEF.md
# Palette colour expander

This block turns a pixel index into an 18-bit colour made of three 6-bit channels (red, green, blue). A pixel pipeline presents an index with a valid strobe. One cycle later the block returns the expanded colour with its own valid flag. Four expansion modes are chosen per index by a 2-bit mode input.

Two modes read a 256-entry table of 16-bit raw palette words and unpack each word as either 5:6:5 or 5:5:5 plus a shared intensity bit. The other two modes build each channel from a 4-bit intensity taken from one of three lookup registers. In one of these the index is split into 3/3/2 bit fields. In the other the low three index bits pick the same nibble position in every register.

A simple word-oriented bus port writes and reads both the palette table and the lookup registers, so software can load colours while the pixel side keeps running.

Top module: `palette_expander`

## Requirements
- R1: `col_valid` is high exactly one cycle after a cycle in which `idx_valid` was high, and low otherwise.
- R2: When `idx_valid` is low, `col_r`, `col_g` and `col_b` keep the value they last had.
- R3: Mode 0 (5:6:5) produces red = {raw[15:11],0}, green = raw[10:5] and blue = {raw[4:0],0}, where raw is the palette word at the index.
- R4: Mode 1 (5:5:5 with intensity) produces red = {raw[15:11],raw[0]}, green = {raw[10:6],raw[0]} and blue = {raw[5:1],raw[0]}.
- R5: Mode 2 (3/3/2 split) takes the red nibble at position idx[7:5] of the red register, the green nibble at position idx[4:2] of the green register, and the blue nibble at position idx[1:0] of the blue register. Nibble position k is bits [4k+3:4k]. Each channel is its nibble followed by two zero bits.
- R6: Mode 3 (direct) uses k = idx[2:0] as the nibble position in all three registers and ignores idx[7:3]. The blue channel is 0 when k is 4 or more. The channel format is the same as in R5.
- R7: Palette entry i sits at bus address 0x400 + 4*i. Only wdata[15:0] is stored. A read returns the entry zero-extended to 32 bits on `bus_rdata`, one cycle after the read strobe, and `bus_rdata` holds until the next read.
- R8: A palette write changes lookups presented from the next cycle on. A lookup presented in the same cycle as the write sees the old word.
- R9: The lookup registers are red at address 0x000 (32 bits), green at 0x004 (32 bits) and blue at 0x008 (16 bits). A write to blue drops wdata[31:16], and a read of blue returns zeros in bits [31:16].
- R10: After reset, `col_valid`, the three colour outputs, all lookup registers and `bus_rdata` are 0.
- R11: Writes to addresses below 0x400 other than the three lookup registers change nothing. Reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Expansion mode, sampled with the index (0 5:6:5, 1 5:5:5+I, 2 3/3/2 split, 3 direct) |
| idx_valid | input | 1 | Index strobe |
| idx | input | 8 | Pixel index |
| col_valid | output | 1 | Colour valid, one cycle after the index |
| col_r | output | 6 | Red channel |
| col_g | output | 6 | Green channel |
| col_b | output | 6 | Blue channel |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 11 | Byte address, bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read strobe |

## Verification
On every cycle the assertions check the valid delay and the holding of the colour between strobes. They also check bit-level properties of each mode: zero low bits in the nibble modes, a single shared low bit in the 5:5:5 mode, even red and blue in the 5:6:5 mode, and a zero blue channel for direct positions 4 to 7. They further check that the upper half of a blue-register read is zero. Only the bench's scenarios can show that the right palette word or nibble was picked for each index, that the bus address map is correct, that a write in the same cycle as a lookup is seen one cycle late, and that unmapped writes leave everything intact.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int unsigned CH_W  = 6;
    localparam int unsigned NIB_W = 4;

    typedef enum logic [1:0] {
        MODE_TFT565  = 2'd0,
        MODE_TFT5551 = 2'd1,
        MODE_STN332  = 2'd2,
        MODE_STNDIR  = 2'd3
    } pal_mode_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

endpackage

// File: rtl/pal_nib_pick.sv
module pal_nib_pick #(
    parameter int unsigned LUT_W = 32,
    parameter int unsigned NIB_W = 4,
    parameter int unsigned SEL_W = 3,
    localparam int unsigned NIBS = LUT_W / NIB_W
) (
    input  logic [LUT_W-1:0] lut,
    input  logic [SEL_W-1:0] sel,
    output logic [NIB_W-1:0] nib
);

    // Positions past the register's last nibble read as zero.
    always_comb begin
        nib = '0;
        for (int k = 0; k < NIBS; k++) begin
            if (sel == SEL_W'(k)) begin
                nib = lut[k*NIB_W +: NIB_W];
            end
        end
    end

endmodule

// File: rtl/pal_regs.sv
module pal_regs #(
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned RAW_W    = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned LUT_RG_W = 32,
    parameter int unsigned LUT_B_W  = 16,
    localparam int unsigned ADDR_W  = IDX_W + 3,
    localparam int unsigned DEPTH   = 1 << IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [IDX_W-1:0]    lk_idx,
    output logic [RAW_W-1:0]    lk_raw,
    output logic [LUT_RG_W-1:0] lut_r,
    output logic [LUT_RG_W-1:0] lut_g,
    output logic [LUT_B_W-1:0]  lut_b
);

    localparam logic [IDX_W-1:0] SLOT_RED = IDX_W'(0);
    localparam logic [IDX_W-1:0] SLOT_GRN = IDX_W'(1);
    localparam logic [IDX_W-1:0] SLOT_BLU = IDX_W'(2);

    typedef struct packed {
        logic [LUT_RG_W-1:0] lr;
        logic [LUT_RG_W-1:0] lg;
        logic [LUT_B_W-1:0]  lb;
        logic [DATA_W-1:0]   rdata;
    } regs_t;

    regs_t st_d, st_q;

    logic [RAW_W-1:0] pal_mem [DEPTH];
    logic             pal_hit;
    logic             pal_we;
    logic [IDX_W-1:0] slot;
    logic             unused_addr_lsb;

    assign unused_addr_lsb = ^bus_addr[1:0];

    always_comb begin
        pal_hit = bus_addr[ADDR_W-1];
        slot    = bus_addr[ADDR_W-2:2];
        pal_we  = bus_sel && bus_wr && pal_hit;
        st_d    = st_q;

        if (bus_sel && bus_wr && !pal_hit) begin
            case (slot)
                SLOT_RED: st_d.lr = bus_wdata[LUT_RG_W-1:0];
                SLOT_GRN: st_d.lg = bus_wdata[LUT_RG_W-1:0];
                SLOT_BLU: st_d.lb = bus_wdata[LUT_B_W-1:0];
                default:  ;
            endcase
        end

        if (bus_sel && !bus_wr) begin
            st_d.rdata = '0;
            if (pal_hit) begin
                st_d.rdata[RAW_W-1:0] = pal_mem[slot];
            end else begin
                case (slot)
                    SLOT_RED: st_d.rdata[LUT_RG_W-1:0] = st_q.lr;
                    SLOT_GRN: st_d.rdata[LUT_RG_W-1:0] = st_q.lg;
                    SLOT_BLU: st_d.rdata[LUT_B_W-1:0]  = st_q.lb;
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Table storage carries no reset; software loads it before use.
    always_ff @(posedge clk) begin
        if (pal_we) begin
            pal_mem[slot] <= bus_wdata[RAW_W-1:0];
        end
    end

    assign lk_raw    = pal_mem[lk_idx];
    assign lut_r     = st_q.lr;
    assign lut_g     = st_q.lg;
    assign lut_b     = st_q.lb;
    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/pal_expand.sv
module pal_expand
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned RAW_W    = 16,
    parameter int unsigned LUT_RG_W = 32,
    parameter int unsigned LUT_B_W  = 16,
    localparam int unsigned SEL_W   = 3,
    localparam int unsigned R_FLD   = 3,
    localparam int unsigned G_FLD   = 3,
    localparam int unsigned B_FLD   = IDX_W - R_FLD - G_FLD,
    localparam int unsigned NCH     = 3
) (
    input  pal_mode_e           mode,
    input  logic [IDX_W-1:0]    idx,
    input  logic [RAW_W-1:0]    raw,
    input  logic [LUT_RG_W-1:0] lut_r,
    input  logic [LUT_RG_W-1:0] lut_g,
    input  logic [LUT_B_W-1:0]  lut_b,
    output rgb_t                col
);

    logic [SEL_W-1:0] sel [NCH];
    logic [NIB_W-1:0] nib [NCH];

    always_comb begin
        if (mode == MODE_STNDIR) begin
            sel[0] = idx[SEL_W-1:0];
            sel[1] = idx[SEL_W-1:0];
            sel[2] = idx[SEL_W-1:0];
        end else begin
            sel[0] = idx[IDX_W-1 -: R_FLD];
            sel[1] = idx[IDX_W-R_FLD-1 -: G_FLD];
            sel[2] = SEL_W'(idx[B_FLD-1:0]);
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int unsigned LW = (c == 2) ? LUT_B_W : LUT_RG_W;
        logic [LW-1:0] lut_c;
        if (c == 0) begin : g_red
            assign lut_c = lut_r;
        end else if (c == 1) begin : g_grn
            assign lut_c = lut_g;
        end else begin : g_blu
            assign lut_c = lut_b;
        end
        pal_nib_pick #(
            .LUT_W (LW),
            .NIB_W (NIB_W),
            .SEL_W (SEL_W)
        ) u_pick (
            .lut (lut_c),
            .sel (sel[c]),
            .nib (nib[c])
        );
    end

    always_comb begin
        col = '0;
        case (mode)
            MODE_TFT565: begin
                col.r = {raw[15:11], 1'b0};
                col.g = raw[10:5];
                col.b = {raw[4:0], 1'b0};
            end
            MODE_TFT5551: begin
                col.r = {raw[15:11], raw[0]};
                col.g = {raw[10:6], raw[0]};
                col.b = {raw[5:1], raw[0]};
            end
            default: begin
                col.r = {nib[0], 2'b00};
                col.g = {nib[1], 2'b00};
                col.b = {nib[2], 2'b00};
            end
        endcase
    end

endmodule

// File: rtl/palette_expander.sv
module palette_expander
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned RAW_W    = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned LUT_RG_W = 32,
    parameter int unsigned LUT_B_W  = 16,
    localparam int unsigned ADDR_W  = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              idx_valid,
    input  logic [IDX_W-1:0]  idx,
    output logic              col_valid,
    output logic [CH_W-1:0]   col_r,
    output logic [CH_W-1:0]   col_g,
    output logic [CH_W-1:0]   col_b,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    typedef struct packed {
        logic vld;
        rgb_t col;
    } out_t;

    out_t o_d, o_q;

    logic [RAW_W-1:0]    lk_raw;
    logic [LUT_RG_W-1:0] lut_r;
    logic [LUT_RG_W-1:0] lut_g;
    logic [LUT_B_W-1:0]  lut_b;
    rgb_t                new_col;

    pal_regs #(
        .IDX_W    (IDX_W),
        .RAW_W    (RAW_W),
        .DATA_W   (DATA_W),
        .LUT_RG_W (LUT_RG_W),
        .LUT_B_W  (LUT_B_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lk_idx    (idx),
        .lk_raw    (lk_raw),
        .lut_r     (lut_r),
        .lut_g     (lut_g),
        .lut_b     (lut_b)
    );

    pal_expand #(
        .IDX_W    (IDX_W),
        .RAW_W    (RAW_W),
        .LUT_RG_W (LUT_RG_W),
        .LUT_B_W  (LUT_B_W)
    ) u_expand (
        .mode  (pal_mode_e'(mode)),
        .idx   (idx),
        .raw   (lk_raw),
        .lut_r (lut_r),
        .lut_g (lut_g),
        .lut_b (lut_b),
        .col   (new_col)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = idx_valid;
        if (idx_valid) begin
            o_d.col = new_col;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign col_valid = o_q.vld;
    assign col_r     = o_q.col.r;
    assign col_g     = o_q.col.g;
    assign col_b     = o_q.col.b;

endmodule

// File: rtl/palette_expander_chk.sv
module palette_expander_chk #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = IDX_W + 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              idx_valid,
    input logic [IDX_W-1:0]  idx,
    input logic              col_valid,
    input logic [5:0]        col_r,
    input logic [5:0]        col_g,
    input logic [5:0]        col_b,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata
);

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid |=> col_valid); // R1

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_valid |=> !col_valid); // R1

    AST_COLOUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_valid |=> $stable({col_r, col_g, col_b})); // R2

    AST_RGB565_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && mode == 2'd0) |=> (col_r[0] == 1'b0 && col_b[0] == 1'b0)); // R3

    AST_INTENSITY_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && mode == 2'd1) |=> (col_r[0] == col_g[0] && col_g[0] == col_b[0])); // R4

    AST_NIBBLE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && mode[1]) |=> (col_r[1:0] == 2'b00 && col_g[1:0] == 2'b00
                                    && col_b[1:0] == 2'b00)); // R5

    AST_DIRECT_BLUE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && mode == 2'd3 && idx[2]) |=> (col_b == 6'd0)); // R6

    AST_BLUE_READ_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(2))
            |=> (bus_rdata[DATA_W-1:16] == '0)); // R9

endmodule

bind palette_expander palette_expander_chk #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .idx_valid (idx_valid),
    .idx       (idx),
    .col_valid (col_valid),
    .col_r     (col_r),
    .col_g     (col_g),
    .col_b     (col_b),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/test_palette_expander.sv
module test_palette_expander;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        idx_valid = 1'b0;
    logic [7:0]  idx = 8'd0;
    logic        col_valid;
    logic [5:0]  col_r, col_g, col_b;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [10:0] bus_addr = 11'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    palette_expander i_palette_expander (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .idx_valid (idx_valid),
        .idx       (idx),
        .col_valid (col_valid),
        .col_r     (col_r),
        .col_g     (col_g),
        .col_b     (col_b),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // ---------------- reference model ----------------
    int unsigned m_pal [256];
    int unsigned m_lr = 0, m_lg = 0, m_lb = 0;
    int unsigned m_r = 0, m_g = 0, m_b = 0, m_rd = 0;
    bit          m_vld = 0;
    string       m_ctag = "R10";
    string       m_rtag = "R10";

    function automatic int unsigned nib(int unsigned word, int unsigned pos);
        return (word >> (4 * pos)) & 15;
    endfunction

    task automatic expect_col(input int unsigned md, input int unsigned ix,
                              output int unsigned r, output int unsigned g,
                              output int unsigned b, output string tag);
        int unsigned raw, k;
        raw = m_pal[ix];
        case (md)
            0: begin
                r = ((raw >> 11) & 31) * 2; g = (raw >> 5) & 63; b = (raw & 31) * 2;
                tag = "R3";
            end
            1: begin
                r = ((raw >> 11) & 31) * 2 + (raw & 1);
                g = ((raw >> 6) & 31) * 2 + (raw & 1);
                b = ((raw >> 1) & 31) * 2 + (raw & 1);
                tag = "R4";
            end
            2: begin
                r = nib(m_lr, (ix >> 5) & 7) * 4;
                g = nib(m_lg, (ix >> 2) & 7) * 4;
                b = nib(m_lb, ix & 3) * 4;
                tag = "R5";
            end
            default: begin
                k = ix % 8;
                r = nib(m_lr, k) * 4;
                g = nib(m_lg, k) * 4;
                b = (k < 4) ? nib(m_lb, k) * 4 : 0;
                tag = "R6";
            end
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_vld = 0; m_r = 0; m_g = 0; m_b = 0; m_rd = 0;
            m_lr = 0; m_lg = 0; m_lb = 0;
            m_ctag = "R10"; m_rtag = "R10";
        end else begin
            int unsigned a;
            a = bus_addr;
            m_vld = idx_valid;
            // lookup sees the table before any write of this same cycle (R8)
            if (idx_valid) expect_col(mode, idx, m_r, m_g, m_b, m_ctag);
            else m_ctag = "R2";
            if (bus_sel && !bus_wr) begin
                if (a >= 1024) begin m_rd = m_pal[(a - 1024) / 4]; m_rtag = "R7"; end
                else case (a / 4)
                    0: begin m_rd = m_lr; m_rtag = "R9"; end
                    1: begin m_rd = m_lg; m_rtag = "R9"; end
                    2: begin m_rd = m_lb; m_rtag = "R9"; end
                    default: begin m_rd = 0; m_rtag = "R11"; end
                endcase
            end
            if (bus_sel && bus_wr) begin
                if (a >= 1024) m_pal[(a - 1024) / 4] = bus_wdata & 32'hFFFF;
                else case (a / 4)
                    0: m_lr = bus_wdata;
                    1: m_lg = bus_wdata;
                    2: m_lb = bus_wdata & 32'hFFFF;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- comparison ----------------
    task automatic chk(input bit ok, input string tag, input string what,
                       input int unsigned act, input int unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk(col_valid == m_vld, rst_n ? "R1" : "R10", "col_valid", col_valid, m_vld);
            chk(col_r == m_r, m_ctag, "col_r", col_r, m_r);
            chk(col_g == m_g, m_ctag, "col_g", col_g, m_g);
            chk(col_b == m_b, m_ctag, "col_b", col_b, m_b);
            chk(bus_rdata == m_rd, m_rtag, "bus_rdata", bus_rdata, m_rd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input bit sel, input bit wr, input int unsigned a,
                       input int unsigned d, input bit v, input int unsigned md,
                       input int unsigned ix);
        @(negedge clk);
        #1;
        bus_sel = sel; bus_wr = wr; bus_addr = 11'(a); bus_wdata = d;
        idx_valid = v; mode = 2'(md); idx = 8'(ix);
    endtask

    task automatic bwr(input int unsigned a, input int unsigned d);
        cyc(1, 1, a, d, 0, 0, 0);
    endtask

    task automatic brd(input int unsigned a);
        cyc(1, 0, a, 0, 0, 0, 0);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual=100000 cycles expected=finish");
            finish_run();
        end
    end

    initial begin
        repeat (4) idle();              // R10 reset values compared each cycle
        @(negedge clk); #1 rst_n = 1'b1;
        idle();

        // R9 lookup registers, blue upper half dropped
        bwr(0, 32'h7A3FC150);
        bwr(4, 32'h0F1E2D3C);
        bwr(8, 32'hFFFFB5E9);
        brd(0); brd(4); brd(8);

        // R7 fill the table, upper data bits must be dropped
        for (int i = 0; i < 256; i++) begin
            bwr(1024 + 4 * i, 32'hA5A50000 | ((i * 40503 + 12345) & 32'hFFFF));
        end
        brd(1024); brd(1024 + 4 * 77); brd(2044);
        idle(); idle();                 // R7 read data holds

        // R11 unmapped writes and reads
        bwr(12, 32'hDEADBEEF);
        bwr(1020, 32'h12345678);
        brd(12); brd(256); brd(1020);
        brd(0); brd(4); brd(8);         // R11 registers untouched

        // R3..R6 every mode over all indices, with gaps (R1, R2)
        for (int md = 0; md < 4; md++) begin
            for (int i = 0; i < 256; i++) begin
                cyc(0, 0, 0, 0, (i % 3) != 2, md, i);
            end
        end

        // R8 write and lookup of the same entry in one cycle, then next cycle
        cyc(1, 1, 1024 + 4 * 20, 32'h0000F81F, 1, 0, 20);
        cyc(0, 0, 0, 0, 1, 0, 20);
        cyc(1, 1, 0, 32'h89ABCDEF, 1, 2, 8'hE7);     // R8 register write same cycle
        cyc(0, 0, 0, 0, 1, 2, 8'hE7);
        cyc(0, 0, 0, 0, 1, 3, 8'hFD);                // R6 upper bits ignored
        cyc(0, 0, 0, 0, 1, 1, 20);
        idle(); idle();
        finish_run();
    end

endmodule